// File: doc/BRIEF.md
# Serial Control Register Bank for a Clock Synthesizer

This block is the two-wire serial slave and control register store of a clock synthesizer. A bus master addresses it at one of two device addresses, picked by a strapping input, and then reads or writes one or more bytes starting from a register index. Eight read/write control registers sit at indices 0x0 to 0x7. A write-only command register sits at 0x8. Three read-only registers sit at 0x10 to 0x12: two identification bytes and a status byte that carries the lock indication of the loop.

Four of the control registers (0x1, 0x2, 0x3 and 0x5) are double-buffered. The bus writes only their shadow copies, and those are the copies read back. The working copies on the output ports change only when a command byte is written to 0x8. An upper command nibble of 5h loads the three loop registers and gives a one-clock loop reset strobe. A lower nibble of Ah loads the delay-line register and gives a one-clock delay reset strobe. The other four registers drive their outputs directly.

The bus lines are synchronized into the system clock domain and edge-detected. A byte-level state machine moves through these states. IDLE is left on a start condition. RX shifts in a byte on rising SCL edges. ACK drives the acknowledge. TX shifts out a read byte on falling SCL edges. RACK samples the master's acknowledge. RNEXT waits for the falling edge that begins the next read byte. The transitions are: IDLE to RX on start; RX to ACK after eight bits, or RX to IDLE when the address does not match; ACK to TX after a read address, or ACK to RX otherwise; TX to RACK after eight bits; RACK to RNEXT on ACK, or RACK to IDLE on NACK; RNEXT to TX. A start condition in any state goes to RX, and a stop condition in any state goes to IDLE.

Top module: `clkgen_i2c_regbank`

## Requirements
- R1: The 8-bit write address is 4Ch when `addr_sel` is 0 and 4Eh when it is 1. The read address is the write address plus one. Any other address byte is not acknowledged, and the slave stays off the bus until the next start condition.
- R2: A write transaction is start, write address, index byte, then data bytes, each byte sent MSB first. The slave acknowledges each byte by holding SDA low during the ninth SCL pulse.
- R3: A read is a write address and an index byte, then a repeated start, then the read address. After that the slave returns register bytes MSB first, one per SCL pulse. A NACK from the master ends the read.
- R4: After each data byte that is written, or read and acknowledged, bits 3:0 of the index increment modulo 16. Bits 7:4 never change, so 0x0F is followed by 0x00 and 0x1F is followed by 0x10.
- R5: Reset values are: 0x0 = 01h, 0x1 = 03h, 0x2 = FFh, 0x3 = 0Fh, 0x4 = 00h, 0x5 = 03h, 0x6 = 00h, 0x7 = 00h. Shadow and working copies both take these values. Both strobes are low after reset.
- R6: Registers 0x0 to 0x7 read back the last value written. For 0x1, 0x2, 0x3 and 0x5 the read returns the shadow copy, and a write leaves the working output unchanged until a load.
- R7: A byte written to 0x8 with bits 7:4 = 5h copies shadows 0x1, 0x2 and 0x3 to `loop_out`, `fb_lo_out` and `fb_hi_out`, and pulses `pll_rst_pulse`.
- R8: A byte written to 0x8 with bits 3:0 = Ah copies shadow 0x5 to `dly_out` and pulses `dly_rst_pulse`. A command byte that matches neither nibble has no effect, and 5Ah does both loads.
- R9: Index 0x10 reads CHIP_ID (17h), index 0x11 reads CHIP_REV (01h), and index 0x12 reads `pll_locked` in bit 1 with all other bits 0.
- R10: Reads of 0x8 and of undefined indices return 00h. Writes to read-only or undefined indices are acknowledged and have no effect.
- R11: Each strobe is high for exactly one system clock per command byte.
- R12: A stop condition ends a transaction without writing a partly sent byte. A repeated start in the middle of a transaction begins a new address phase, and the earlier index is left with no data written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| addr_sel | input | 1 | Selects the device address pair |
| pll_locked | input | 1 | Lock status of the loop |
| sda_low | output | 1 | 1 pulls SDA low (open-drain drive) |
| ctl_out | output | 8 | Register 0x0, direct |
| loop_out | output | 8 | Working copy of 0x1 |
| fb_lo_out | output | 8 | Working copy of 0x2 |
| fb_hi_out | output | 8 | Working copy of 0x3 |
| phase_out | output | 8 | Register 0x4, direct |
| dly_out | output | 8 | Working copy of 0x5 |
| oe_out | output | 8 | Register 0x6, direct |
| osc_out | output | 8 | Register 0x7, direct |
| pll_rst_pulse | output | 1 | One-clock loop reset strobe |
| dly_rst_pulse | output | 1 | One-clock delay-line reset strobe |

## Verification
Single-byte write-then-read pairs run over the direct, shadowed, command, read-only and undefined indices. They separate storage from decoding: writable indices echo the byte, while the others return fixed values or 00h. Multi-byte bursts that start at 0x0F, 0x1F and 0x00 separate lower-nibble wrapping from a full-index increment. Command bytes 50h, 0Ah, 3Bh and 5Ah tell each nibble decode apart from its neighbour and from a no-op. Both address-select settings and aborted transactions show that only matching, complete bytes take effect.

// File: rtl/clkgen_i2c_pkg.sv
`timescale 1ns/1ps
package clkgen_i2c_pkg;

    localparam int unsigned DW     = 8;   // register width
    localparam int unsigned IW     = 8;   // index width
    localparam int unsigned NIB    = 4;   // auto-increment field width
    localparam int unsigned NREG   = 8;   // read/write register count
    localparam int unsigned LOCK_BIT = 1;

    localparam logic [IW-1:0] IDX_CMD  = 8'h08;
    localparam logic [IW-1:0] IDX_ID   = 8'h10;
    localparam logic [IW-1:0] IDX_REV  = 8'h11;
    localparam logic [IW-1:0] IDX_STAT = 8'h12;

    localparam logic [NIB-1:0] PLL_NIB = 4'h5;
    localparam logic [NIB-1:0] DLY_NIB = 4'hA;

    typedef enum logic [2:0] {
        S_IDLE, S_RX, S_ACK, S_TX, S_RACK, S_RNEXT
    } i2c_state_t;

    typedef enum logic [1:0] {
        K_DEV, K_IDX, K_DATA
    } byte_kind_t;

    function automatic logic [DW-1:0] shadow_reset(input int unsigned i);
        case (i)
            0:       return 8'h01;
            1:       return 8'h03;
            2:       return 8'hFF;
            3:       return 8'h0F;
            5:       return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/i2c_pin_sync.sv
`timescale 1ns/1ps
module i2c_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign sda_lvl   = sda_s;
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // SDA edges count as bus conditions only with SCL high on both samples
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_byte_fsm.sv
`timescale 1ns/1ps
module i2c_byte_fsm
    import clkgen_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR_BASE = 7'h26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_lvl,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          addr_sel,
    input  logic [DW-1:0] rd_data,
    output logic [IW-1:0] idx,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic          sda_low
);
    localparam int unsigned CW = $clog2(DW + 1);
    localparam logic [CW-1:0] LAST_RX = CW'(DW);
    localparam logic [CW-1:0] LAST_TX = CW'(DW - 1);

    i2c_state_t    state, nxt;
    byte_kind_t    kind;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] shreg, txreg;
    logic          rw;
    logic          addr_hit;
    logic [IW-1:0] idx_inc;

    assign addr_hit = (shreg[DW-1:1] == {DEV_ADDR_BASE[6:1], addr_sel});
    assign idx_inc  = {idx[IW-1:NIB], idx[NIB-1:0] + 1'b1};

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  nxt = state;
            S_RX:    if (scl_fall && bit_cnt == LAST_RX)
                         nxt = (kind == K_DEV && !addr_hit) ? S_IDLE : S_ACK;
            S_ACK:   if (scl_fall) nxt = (kind == K_DEV && rw) ? S_TX : S_RX;
            S_TX:    if (scl_fall && bit_cnt == LAST_TX) nxt = S_RACK;
            S_RACK:  if (scl_rise) nxt = sda_lvl ? S_IDLE : S_RNEXT;
            S_RNEXT: if (scl_fall) nxt = S_TX;
            default: nxt = S_IDLE;
        endcase
        if (start_det)     nxt = S_RX;
        else if (stop_det) nxt = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind    <= K_DEV;
            bit_cnt <= '0;
            shreg   <= '0;
            txreg   <= '0;
            rw      <= 1'b0;
            idx     <= '0;
            sda_low <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                kind    <= K_DEV;
                bit_cnt <= '0;
                sda_low <= 1'b0;
            end else if (stop_det) begin
                sda_low <= 1'b0;
            end else begin
                unique case (state)
                    S_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[DW-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (scl_fall && bit_cnt == LAST_RX) begin
                            unique case (kind)
                                K_DEV: begin
                                    rw      <= shreg[0];
                                    sda_low <= addr_hit;
                                end
                                K_IDX: begin
                                    idx     <= shreg;
                                    sda_low <= 1'b1;
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= idx;
                                    wr_data <= shreg;
                                    idx     <= idx_inc;
                                    sda_low <= 1'b1;
                                end
                            endcase
                        end
                    end
                    S_ACK: if (scl_fall) begin
                        bit_cnt <= '0;
                        if (kind == K_DEV && rw) begin
                            txreg   <= rd_data;
                            sda_low <= ~rd_data[DW-1];
                        end else begin
                            sda_low <= 1'b0;
                            kind    <= (kind == K_DEV) ? K_IDX : K_DATA;
                        end
                    end
                    S_TX: if (scl_fall) begin
                        if (bit_cnt == LAST_TX) begin
                            sda_low <= 1'b0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            txreg   <= {txreg[DW-2:0], 1'b0};
                            sda_low <= ~txreg[DW-2];
                        end
                    end
                    S_RACK: if (scl_rise && !sda_lvl) idx <= idx_inc;
                    S_RNEXT: if (scl_fall) begin
                        bit_cnt <= '0;
                        txreg   <= rd_data;
                        sda_low <= ~rd_data[DW-1];
                    end
                    default: begin end
                endcase
            end
        end
    end

    // R2: the slave drives SDA only while acknowledging or sending
    p_drive_states_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low |-> (state == S_ACK || state == S_TX));

    // R4: a written byte advances only the lower index nibble
    p_wr_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx[IW-1:NIB] == idx[IW-1:NIB] &&
                   idx[NIB-1:0] == wr_idx[NIB-1:0] + 4'd1));

    // R4: an acknowledged read byte advances only the lower index nibble
    p_rd_nibble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RACK && nxt == S_RNEXT) |=>
            (idx == {$past(idx[IW-1:NIB]), $past(idx[NIB-1:0]) + 4'd1}));

    // R3: a NACK from the master ends the read
    p_nack_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RACK && scl_rise && sda_lvl && !start_det && !stop_det)
            |=> state == S_IDLE);

endmodule

// File: rtl/clkgen_reg_store.sv
`timescale 1ns/1ps
module clkgen_reg_store
    import clkgen_i2c_pkg::*;
#(
    parameter logic [DW-1:0] CHIP_ID  = 8'h17,
    parameter logic [DW-1:0] CHIP_REV = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    input  logic          pll_locked,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] ctl_out,
    output logic [DW-1:0] loop_out,
    output logic [DW-1:0] fb_lo_out,
    output logic [DW-1:0] fb_hi_out,
    output logic [DW-1:0] phase_out,
    output logic [DW-1:0] dly_out,
    output logic [DW-1:0] oe_out,
    output logic [DW-1:0] osc_out,
    output logic          pll_rst_pulse,
    output logic          dly_rst_pulse
);
    localparam int unsigned SELW = $clog2(NREG);

    logic [DW-1:0] shadow [NREG];
    logic          cmd_wr, pll_hit, dly_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) shadow[i] <= shadow_reset(i);
        end else begin
            for (int i = 0; i < NREG; i++)
                if (wr_en && wr_idx == IW'(i)) shadow[i] <= wr_data;
        end
    end

    assign cmd_wr  = wr_en && (wr_idx == IDX_CMD);
    assign pll_hit = cmd_wr && (wr_data[DW-1:NIB] == PLL_NIB);
    assign dly_hit = cmd_wr && (wr_data[NIB-1:0] == DLY_NIB);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loop_out      <= shadow_reset(1);
            fb_lo_out     <= shadow_reset(2);
            fb_hi_out     <= shadow_reset(3);
            dly_out       <= shadow_reset(5);
            pll_rst_pulse <= 1'b0;
            dly_rst_pulse <= 1'b0;
        end else begin
            pll_rst_pulse <= pll_hit;
            dly_rst_pulse <= dly_hit;
            if (pll_hit) begin
                loop_out  <= shadow[1];
                fb_lo_out <= shadow[2];
                fb_hi_out <= shadow[3];
            end
            if (dly_hit) dly_out <= shadow[5];
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx[IW-1:SELW] == '0) begin
            rd_data = shadow[rd_idx[SELW-1:0]];
        end else begin
            case (rd_idx)
                IDX_ID:   rd_data = CHIP_ID;
                IDX_REV:  rd_data = CHIP_REV;
                IDX_STAT: rd_data[LOCK_BIT] = pll_locked;
                default:  rd_data = '0;
            endcase
        end
    end

    assign ctl_out   = shadow[0];
    assign phase_out = shadow[4];
    assign oe_out    = shadow[6];
    assign osc_out   = shadow[7];

    // R11: strobes are one clock wide
    p_pll_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst_pulse |=> !pll_rst_pulse);
    p_dly_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dly_rst_pulse |=> !dly_rst_pulse);

    // R7: loop strobe coincides with the working loop copies matching shadows
    p_pll_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst_pulse |-> (loop_out == shadow[1] && fb_lo_out == shadow[2] &&
                           fb_hi_out == shadow[3]));

    // R8: delay strobe coincides with the working delay copy matching its shadow
    p_dly_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dly_rst_pulse |-> dly_out == shadow[5]);

    // R6: working copies hold without a load
    p_loop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_rst_pulse |-> ($stable(loop_out) && $stable(fb_lo_out) && $stable(fb_hi_out)));
    p_dly_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dly_rst_pulse |-> $stable(dly_out));

endmodule

// File: rtl/clkgen_i2c_regbank.sv
`timescale 1ns/1ps
module clkgen_i2c_regbank
    import clkgen_i2c_pkg::*;
#(
    parameter int unsigned   SYNC_STAGES   = 2,
    parameter logic [6:0]    DEV_ADDR_BASE = 7'h26,
    parameter logic [DW-1:0] CHIP_ID       = 8'h17,
    parameter logic [DW-1:0] CHIP_REV      = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          addr_sel,
    input  logic          pll_locked,
    output logic          sda_low,
    output logic [DW-1:0] ctl_out,
    output logic [DW-1:0] loop_out,
    output logic [DW-1:0] fb_lo_out,
    output logic [DW-1:0] fb_hi_out,
    output logic [DW-1:0] phase_out,
    output logic [DW-1:0] dly_out,
    output logic [DW-1:0] oe_out,
    output logic [DW-1:0] osc_out,
    output logic          pll_rst_pulse,
    output logic          dly_rst_pulse
);
    logic          scl_rise, scl_fall, sda_lvl, start_det, stop_det;
    logic [IW-1:0] idx, wr_idx;
    logic [DW-1:0] wr_data, rd_data;
    logic          wr_en;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_byte_fsm #(.DEV_ADDR_BASE(DEV_ADDR_BASE)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_lvl   (sda_lvl),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .rd_data   (rd_data),
        .idx       (idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_low   (sda_low)
    );

    clkgen_reg_store #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_data       (wr_data),
        .rd_idx        (idx),
        .pll_locked    (pll_locked),
        .rd_data       (rd_data),
        .ctl_out       (ctl_out),
        .loop_out      (loop_out),
        .fb_lo_out     (fb_lo_out),
        .fb_hi_out     (fb_hi_out),
        .phase_out     (phase_out),
        .dly_out       (dly_out),
        .oe_out        (oe_out),
        .osc_out       (osc_out),
        .pll_rst_pulse (pll_rst_pulse),
        .dly_rst_pulse (dly_rst_pulse)
    );

endmodule

// File: tb/tb_clkgen_i2c_regbank.sv
`timescale 1ns/1ps
module tb_clkgen_i2c_regbank;
    localparam int H = 10;
    localparam logic [7:0] WA0 = 8'h4C;
    localparam logic [7:0] WA1 = 8'h4E;

    // table: {index, write data, expected readback}
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {8'h00, 8'hA5, 8'hA5},
        {8'h04, 8'h3C, 8'h3C},
        {8'h06, 8'h5A, 8'h5A},
        {8'h07, 8'h81, 8'h81},
        {8'h01, 8'h26, 8'h26},
        {8'h10, 8'h55, 8'h17},
        {8'h11, 8'hAA, 8'h01},
        {8'h09, 8'h77, 8'h00},
        {8'h0F, 8'h12, 8'h00},
        {8'h08, 8'h00, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic addr_sel = 1'b0;
    logic pll_locked = 1'b0;
    logic sda_low;
    logic sda_bus;
    logic [7:0] ctl_out, loop_out, fb_lo_out, fb_hi_out, phase_out, dly_out, oe_out, osc_out;
    logic pll_rst_pulse, dly_rst_pulse;

    assign sda_bus = sda_m & ~sda_low;

    clkgen_i2c_regbank dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .addr_sel(addr_sel), .pll_locked(pll_locked), .sda_low(sda_low),
        .ctl_out(ctl_out), .loop_out(loop_out), .fb_lo_out(fb_lo_out),
        .fb_hi_out(fb_hi_out), .phase_out(phase_out), .dly_out(dly_out),
        .oe_out(oe_out), .osc_out(osc_out),
        .pll_rst_pulse(pll_rst_pulse), .dly_rst_pulse(dly_rst_pulse)
    );

    always #2.5 clk = ~clk;

    int errs = 0, checks = 0;
    int pll_cnt = 0, dly_cnt = 0, pll_run = 0, dly_run = 0, max_run = 0;

    always @(posedge clk) begin
        if (pll_rst_pulse === 1'b1) begin pll_cnt++; pll_run++; end else pll_run = 0;
        if (dly_rst_pulse === 1'b1) begin dly_cnt++; dly_run++; end else dly_run = 0;
        if (pll_run > max_run) max_run = pll_run;
        if (dly_run > max_run) max_run = dly_run;
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H);
            scl_m = 1'b1; wt(2 * H);
            scl_m = 1'b0; wt(H);
        end
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        ack = (sda_bus == 1'b0);
        wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H);
            scl_m = 1'b1; wt(H);
            b[i] = sda_bus;
            wt(H);
            scl_m = 1'b0;
        end
        wt(H / 2);
        sda_m = give_ack ? 1'b0 : 1'b1; wt(H);
        scl_m = 1'b1; wt(2 * H);
        scl_m = 1'b0; wt(H);
        sda_m = 1'b1;
    endtask

    task automatic wr_regs(input logic [7:0] wa, input logic [7:0] idx,
                           input logic [7:0] d [4], input int n, output logic acked);
        logic a;
        acked = 1'b1;
        bus_start();
        send_byte(wa, a);  acked &= a;
        send_byte(idx, a); acked &= a;
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], a); acked &= a;
        end
        bus_stop();
        wt(4);
    endtask

    task automatic wr1(input logic [7:0] wa, input logic [7:0] idx,
                       input logic [7:0] v, output logic acked);
        logic [7:0] d [4];
        d = '{v, 8'h00, 8'h00, 8'h00};
        wr_regs(wa, idx, d, 1, acked);
    endtask

    task automatic rd_regs(input logic [7:0] wa, input logic [7:0] idx, input int n,
                           output logic [7:0] q [4], output logic acked);
        logic a;
        q = '{8'h00, 8'h00, 8'h00, 8'h00};
        acked = 1'b1;
        bus_start();
        send_byte(wa, a);  acked &= a;
        send_byte(idx, a); acked &= a;
        bus_start();
        send_byte(wa | 8'h01, a); acked &= a;
        for (int k = 0; k < n; k++) recv_byte(k < n - 1, q[k]);
        bus_stop();
        wt(4);
    endtask

    task automatic rd1(input logic [7:0] wa, input logic [7:0] idx, output logic [7:0] v);
        logic [7:0] q [4];
        logic a;
        rd_regs(wa, idx, 1, q, a);
        v = q[0];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] q [4];
        logic [7:0] v;
        logic ack;

        wt(20);
        rst_n = 1'b1;
        wt(10);

        // R5 reset state at the ports
        chk("R5 ctl_out reset",   ctl_out,   8'h01);
        chk("R5 loop_out reset",  loop_out,  8'h03);
        chk("R5 fb_lo_out reset", fb_lo_out, 8'hFF);
        chk("R5 fb_hi_out reset", fb_hi_out, 8'h0F);
        chk("R5 phase_out reset", phase_out, 8'h00);
        chk("R5 dly_out reset",   dly_out,   8'h03);
        chk("R5 oe/osc reset",    oe_out | osc_out, 8'h00);
        chk("R5 strobes reset",   {6'd0, pll_rst_pulse, dly_rst_pulse}, 8'h00);
        chk("R2 sda idle",        {7'd0, sda_low}, 8'h00);

        // R3 R4 R5 burst reads of reset values
        rd_regs(WA0, 8'h00, 4, q, ack);
        chk("R3 read acked", {7'd0, ack}, 8'h01);
        chk("R5 rd 0x0", q[0], 8'h01);
        chk("R5 rd 0x1", q[1], 8'h03);
        chk("R4 R5 rd 0x2", q[2], 8'hFF);
        chk("R4 R5 rd 0x3", q[3], 8'h0F);
        rd_regs(WA0, 8'h04, 4, q, ack);
        chk("R5 rd 0x4", q[0], 8'h00);
        chk("R5 rd 0x5", q[1], 8'h03);
        chk("R5 rd 0x6", q[2], 8'h00);
        chk("R5 rd 0x7", q[3], 8'h00);

        // table: R2 R3 R6 R10
        for (int vi = 0; vi < NV; vi++) begin
            wr1(WA0, VEC[vi][23:16], VEC[vi][15:8], ack);
            chk($sformatf("R2 R10 write ack idx %02h", VEC[vi][23:16]), {7'd0, ack}, 8'h01);
            rd1(WA0, VEC[vi][23:16], v);
            chk($sformatf("R6 R9 R10 readback idx %02h", VEC[vi][23:16]), v, VEC[vi][7:0]);
        end
        chk("R6 ctl_out direct", ctl_out, 8'hA5);
        chk("R6 loop_out held",  loop_out, 8'h03);
        chk("R8 cmd 00 no strobe", 8'(pll_cnt + dly_cnt), 8'h00);

        // R1 address select
        wr1(WA1, 8'h04, 8'h11, ack);
        chk("R1 wrong address not acked", {7'd0, ack}, 8'h00);
        chk("R1 wrong address no write", phase_out, 8'h3C);
        addr_sel = 1'b1;
        wr1(WA1, 8'h04, 8'h22, ack);
        chk("R1 alt address acked", {7'd0, ack}, 8'h01);
        chk("R1 alt address write", phase_out, 8'h22);
        rd1(WA1, 8'h04, v);
        chk("R1 alt address read", v, 8'h22);
        wr1(WA0, 8'h04, 8'h33, ack);
        chk("R1 old address rejected", {7'd0, ack}, 8'h00);
        addr_sel = 1'b0;

        // R6 R7 shadow then loop load
        wr_regs(WA0, 8'h01, '{8'h44, 8'h34, 8'h02, 8'h00}, 3, ack);
        chk("R6 loop_out before load",  loop_out,  8'h03);
        chk("R6 fb_lo_out before load", fb_lo_out, 8'hFF);
        rd_regs(WA0, 8'h01, 3, q, ack);
        chk("R4 R6 shadow 0x3", q[2], 8'h02);
        wr1(WA0, 8'h08, 8'h50, ack);
        chk("R7 pll strobe count", 8'(pll_cnt), 8'h01);
        chk("R7 loop_out", loop_out, 8'h44);
        chk("R7 fb_lo_out", fb_lo_out, 8'h34);
        chk("R7 fb_hi_out", fb_hi_out, 8'h02);
        chk("R7 no delay load", dly_out, 8'h03);

        // R8 delay load
        wr1(WA0, 8'h05, 8'h02, ack);
        chk("R6 dly_out before load", dly_out, 8'h03);
        wr1(WA0, 8'h08, 8'h0A, ack);
        chk("R8 dly strobe count", 8'(dly_cnt), 8'h01);
        chk("R8 dly_out", dly_out, 8'h02);
        chk("R8 pll untouched", 8'(pll_cnt), 8'h01);
        wr1(WA0, 8'h08, 8'h3B, ack);
        chk("R8 other cmd no strobe", 8'(pll_cnt + dly_cnt), 8'h02);
        wr1(WA0, 8'h08, 8'h5A, ack);
        chk("R8 both strobes", 8'(pll_cnt + dly_cnt), 8'h04);
        chk("R11 strobe width", 8'(max_run), 8'h01);

        // R9 lock status
        pll_locked = 1'b1;
        rd1(WA0, 8'h12, v);
        chk("R9 status locked", v, 8'h02);
        pll_locked = 1'b0;
        rd1(WA0, 8'h12, v);
        chk("R9 status unlocked", v, 8'h00);

        // R4 nibble wrap
        rd_regs(WA0, 8'h1F, 2, q, ack);
        chk("R4 rd 0x1F", q[0], 8'h00);
        chk("R4 wrap to 0x10", q[1], 8'h17);
        wr_regs(WA0, 8'h0F, '{8'h77, 8'h3C, 8'h00, 8'h00}, 2, ack);
        chk("R4 write wrap to 0x00", ctl_out, 8'h3C);

        // R12 aborted transactions
        bus_start();
        send_byte(WA0, ack);
        send_byte(8'h06, ack);
        bus_start();
        send_byte(WA0, ack);
        send_byte(8'h07, ack);
        send_byte(8'h5B, ack);
        bus_stop();
        wt(4);
        chk("R12 restart leaves 0x6", oe_out, 8'h5A);
        chk("R12 restart writes 0x7", osc_out, 8'h5B);
        bus_start();
        send_byte(WA0, ack);
        send_byte(8'h06, ack);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(2 * H);
        scl_m = 1'b0; wt(H);
        bus_stop();
        wt(4);
        chk("R12 stop drops partial byte", oe_out, 8'h5A);
        rd1(WA0, 8'h06, v);
        chk("R12 bus usable after stop", v, 8'h5A);

        finish_run();
    end

endmodule